// File: doc/BRIEF.md
# Quasi-cyclic parity-check matrix descriptor sequencer

This block turns a compact table of a quasi-cyclic parity-check matrix into a stream of block-row descriptors for a decoder's control path. The table sits in an external synchronous ROM. Each 48-bit ROM line packs four 12-bit entries. Every entry is either a (shift, block-column) pair or a row header. A header is recognised by an all-ones shift field, and its column field then gives the number of pairs that follow for that block-row.

A start pulse samples a use-case configuration, made up of a rate group, an A/B table selector, an expansion factor and a mode flag, together with a requested block-row count. From the configuration the block forms the first ROM line to read. It then fetches lines in order and unpacks their entries one by one, crossing line boundaries freely. Headers are absorbed without being emitted. The pairs that follow are offered on a valid/ready output, tagged with the row degree and with first and last markers. After the requested number of block-rows the block raises a done flag. A malformed table stops the walk and raises a sticky error flag.

Top module: `pcm_desc_seq`

## Requirements
- R1: The first ROM line read after start is `rate*128 + slot*16`. When `cfg_mode`=0 the slot is 0, 1 or 2 for `cfg_z` = 27, 54 or 81, and 3 for any other value. When `cfg_mode`=1 the slot is `4 + cfg_ab`, whatever `cfg_z` holds.
- R2: Entry k (k = 0..3) of a line occupies bits [12k+11:12k], with the shift in the upper 7 bits and the column index in the lower 5. Entries are consumed in the order k=0,1,2,3, and reading then moves to the next ROM line.
- R3: An entry with shift 7'h7F is a row header and is never emitted. Its column field d gives the row degree. The next d entries are emitted in order as pairs, each carrying `out_deg`=d, with `out_first` set on the first pair and `out_last` set on the d-th.
- R4: `done` rises after the last pair of the `num_rows`-th block-row has been transferred, and no further pairs are offered after that. If `num_rows`=0, `done` is high in the cycle after start and nothing is emitted.
- R5: A pair transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and all pair fields hold their values.
- R6: A header with degree 0 sets `err`, and no further pairs are emitted.
- R7: A header found where a pair was expected sets `err`, and no further pairs are emitted.
- R8: A non-header entry found where a header was expected sets `err`, and nothing more is emitted.
- R9: `err` and `done` are sticky until the next start. A start pulse, even in the middle of a walk, clears both flags and restarts from the newly configured line.
- R10: After reset, `out_valid`, `done`, `err` and `rom_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads configuration and restarts the walk |
| cfg_rate | input | 2 | Rate group, selects the 128-line region |
| cfg_ab | input | 1 | A/B table selector when `cfg_mode`=1 |
| cfg_z | input | 7 | Expansion factor, selects the table when `cfg_mode`=0 |
| cfg_mode | input | 1 | 0: table chosen by Z, 1: table chosen by A/B |
| num_rows | input | 6 | Number of block-rows to emit |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | 9 | ROM line address |
| rom_data | input | 48 | ROM line, valid one cycle after the read |
| out_valid | output | 1 | Pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_shift | output | 7 | Cyclic shift of the pair |
| out_col | output | 5 | Block-column index of the pair |
| out_deg | output | 5 | Degree of the current block-row |
| out_first | output | 1 | First pair of the block-row |
| out_last | output | 1 | Last pair of the block-row |
| done | output | 1 | Requested block-rows complete (sticky) |
| err | output | 1 | Malformed table detected (sticky) |

## Verification
Random tables with random row degrees are placed in randomly chosen rate and slot regions. This exposes errors in base and offset formation, since each region holds different contents, and errors in entry ordering and in line crossing, since rows start at any entry position. The consumer's ready is drawn at random, with light and heavy stall levels, which separates correct holding behaviour from values that change during a stall. Directed tables cover a zero-degree header, a header inside a row, a missing header, a zero row request and a restart during a walk, so each error path and each flag-clearing path is told apart from the normal end of a walk.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
    localparam int SHIFT_W = 7;
    localparam int COL_W   = 5;
    localparam int ENTRY_W = SHIFT_W + COL_W;
    localparam int ENTRIES = 4;
    localparam int LINE_W  = ENTRY_W * ENTRIES;
    localparam int SEL_W   = $clog2(ENTRIES);
    localparam int ADDR_W  = 9;
    localparam int RATE_W  = 2;
    localparam int Z_W     = 7;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [COL_W-1:0]   col;
    } entry_t;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              ab;
        logic [Z_W-1:0]    z;
        logic              mode;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPT,
        ST_SCAN,
        ST_END
    } walk_st_t;

    function automatic logic is_header(entry_t e);
        return &e.shift;
    endfunction
endpackage

// File: rtl/pcm_cfg_addr.sv
module pcm_cfg_addr
    import pcm_seq_pkg::*;
#(
    parameter int RATE_LINES = 128,
    parameter int SLOT_LINES = 16,
    parameter int Z_SEL0     = 27,
    parameter int Z_SEL1     = 54,
    parameter int Z_SEL2     = 81
) (
    input  cfg_t              cfg,
    output logic [ADDR_W-1:0] line_o
);
    logic [2:0] slot;

    always_comb begin
        if (cfg.mode) begin
            slot = {2'b10, cfg.ab};
        end else if (cfg.z == Z_W'(Z_SEL0)) begin
            slot = 3'd0;
        end else if (cfg.z == Z_W'(Z_SEL1)) begin
            slot = 3'd1;
        end else if (cfg.z == Z_W'(Z_SEL2)) begin
            slot = 3'd2;
        end else begin
            slot = 3'd3;
        end
    end

    assign line_o = ADDR_W'(int'(cfg.rate) * RATE_LINES + int'(slot) * SLOT_LINES);
endmodule

// File: rtl/pcm_line_buf.sv
module pcm_line_buf
    import pcm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [LINE_W-1:0] line_i,
    input  logic [SEL_W-1:0]  sel,
    output entry_t            entry_o
);
    logic [LINE_W-1:0] line_q;
    entry_t            ents [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (cap) begin
            line_q <= line_i;
        end
    end

    for (genvar k = 0; k < ENTRIES; k++) begin : g_unpack
        assign ents[k] = entry_t'(line_q[k*ENTRY_W +: ENTRY_W]);
    end

    assign entry_o = ents[sel];
endmodule

// File: rtl/pcm_walk_ctrl.sv
module pcm_walk_ctrl
    import pcm_seq_pkg::*;
#(
    parameter int ROWS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_line,
    input  logic [ROWS_W-1:0] num_rows,
    input  entry_t            entry_i,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    output logic              cap,
    output logic [SEL_W-1:0]  sel,
    output logic              out_valid,
    output logic [COL_W-1:0]  out_deg,
    output logic              out_first,
    output logic              out_last,
    output logic              done,
    output logic              err
);
    walk_st_t          state;
    logic [ADDR_W-1:0] line_ptr;
    logic [SEL_W-1:0]  slot;
    logic [COL_W-1:0]  remain;
    logic [COL_W-1:0]  deg;
    logic [ROWS_W-1:0] rows_left;
    logic              done_q;
    logic              err_q;

    logic in_scan, want_hdr, hdr, hdr_ok, bad, xfer, row_end, all_end, adv, wrap;

    assign in_scan  = (state == ST_SCAN);
    assign want_hdr = (remain == '0);
    assign hdr      = is_header(entry_i);
    assign hdr_ok   = in_scan && want_hdr && hdr && (entry_i.col != '0);
    assign bad      = in_scan && ((want_hdr && (!hdr || entry_i.col == '0)) ||
                                  (!want_hdr && hdr));
    assign xfer     = in_scan && !want_hdr && !hdr && out_ready;
    assign row_end  = xfer && (remain == COL_W'(1));
    assign all_end  = row_end && (rows_left == ROWS_W'(1));
    assign adv      = hdr_ok || (xfer && !all_end);
    assign wrap     = adv && (slot == SEL_W'(ENTRIES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else if (start) begin
            state <= (num_rows == '0) ? ST_END : ST_FETCH;
        end else begin
            case (state)
                ST_FETCH: state <= ST_CAPT;
                ST_CAPT:  state <= ST_SCAN;
                ST_SCAN: begin
                    if (bad || all_end) begin
                        state <= ST_END;
                    end else if (wrap) begin
                        state <= ST_FETCH;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_ptr <= '0;
            slot     <= '0;
        end else if (start) begin
            line_ptr <= start_line;
            slot     <= '0;
        end else if (adv) begin
            slot <= wrap ? '0 : slot + SEL_W'(1);
            if (wrap) begin
                line_ptr <= line_ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            deg       <= '0;
            rows_left <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else if (start) begin
            remain    <= '0;
            deg       <= '0;
            rows_left <= num_rows;
            done_q    <= (num_rows == '0);
            err_q     <= 1'b0;
        end else begin
            if (hdr_ok) begin
                remain <= entry_i.col;
                deg    <= entry_i.col;
            end else if (xfer) begin
                remain <= remain - COL_W'(1);
            end
            if (row_end) begin
                rows_left <= rows_left - ROWS_W'(1);
            end
            if (all_end) begin
                done_q <= 1'b1;
            end
            if (bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign rom_addr  = line_ptr;
    assign rom_rd    = (state == ST_FETCH);
    assign cap       = (state == ST_CAPT);
    assign sel       = slot;
    assign out_valid = in_scan && !want_hdr && !hdr;
    assign out_deg   = deg;
    assign out_first = (remain == deg);
    assign out_last  = (remain == COL_W'(1));
    assign done      = done_q;
    assign err       = err_q;
endmodule

// File: rtl/pcm_desc_seq.sv
module pcm_desc_seq
    import pcm_seq_pkg::*;
#(
    parameter int ROWS_W     = 6,
    parameter int RATE_LINES = 128,
    parameter int SLOT_LINES = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [RATE_W-1:0]     cfg_rate,
    input  logic                  cfg_ab,
    input  logic [Z_W-1:0]        cfg_z,
    input  logic                  cfg_mode,
    input  logic [ROWS_W-1:0]     num_rows,
    output logic                  rom_rd,
    output logic [ADDR_W-1:0]     rom_addr,
    input  logic [LINE_W-1:0]     rom_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SHIFT_W-1:0]    out_shift,
    output logic [COL_W-1:0]      out_col,
    output logic [COL_W-1:0]      out_deg,
    output logic                  out_first,
    output logic                  out_last,
    output logic                  done,
    output logic                  err
);
    cfg_t              cfg_w;
    logic [ADDR_W-1:0] start_line;
    logic              cap;
    logic [SEL_W-1:0]  sel;
    entry_t            cur;

    assign cfg_w = {cfg_rate, cfg_ab, cfg_z, cfg_mode};

    pcm_cfg_addr #(
        .RATE_LINES (RATE_LINES),
        .SLOT_LINES (SLOT_LINES)
    ) addr_i (
        .cfg    (cfg_w),
        .line_o (start_line)
    );

    pcm_line_buf buf_i (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .line_i  (rom_data),
        .sel     (sel),
        .entry_o (cur)
    );

    pcm_walk_ctrl #(
        .ROWS_W (ROWS_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line (start_line),
        .num_rows   (num_rows),
        .entry_i    (cur),
        .out_ready  (out_ready),
        .rom_addr   (rom_addr),
        .rom_rd     (rom_rd),
        .cap        (cap),
        .sel        (sel),
        .out_valid  (out_valid),
        .out_deg    (out_deg),
        .out_first  (out_first),
        .out_last   (out_last),
        .done       (done),
        .err        (err)
    );

    assign out_shift = cur.shift;
    assign out_col   = cur.col;
endmodule

// File: rtl/pcm_desc_seq_chk.sv
module pcm_desc_seq_chk
    import pcm_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               out_valid,
    input logic               out_ready,
    input logic [SHIFT_W-1:0] out_shift,
    input logic [COL_W-1:0]   out_col,
    input logic [COL_W-1:0]   out_deg,
    input logic               out_first,
    input logic               out_last,
    input logic               done,
    input logic               err
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_shift) &&
        $stable(out_col) && $stable(out_deg) && $stable(out_first) && $stable(out_last)));

    // R3
    no_header_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_shift != '1 && out_deg != '0));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !out_valid);

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !err);
endmodule

bind pcm_desc_seq pcm_desc_seq_chk chk_i (.*);

// File: tb/pcm_desc_seq_tb.sv
`timescale 1ns/1ps
module pcm_desc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_rate = '0;
    logic        cfg_ab = 1'b0;
    logic [6:0]  cfg_z = '0;
    logic        cfg_mode = 1'b0;
    logic [5:0]  num_rows = '0;
    logic        rom_rd;
    logic [8:0]  rom_addr;
    logic [47:0] rom_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [6:0]  out_shift;
    logic [4:0]  out_col, out_deg;
    logic        out_first, out_last, done, err;

    logic [47:0] rom [0:511];
    int checks = 0;
    int errs = 0;
    int stall_lvl = 1;

    logic [6:0] q_shift [$];
    logic [4:0] q_col [$];
    logic [4:0] q_deg [$];
    logic       q_first [$];
    logic       q_last [$];
    logic       exp_err;

    always #2 clk = ~clk;

    always @(posedge clk) if (rom_rd) rom_data <= rom[rom_addr];

    pcm_desc_seq dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int base_of(input logic [1:0] r, input logic ab,
                                   input logic [6:0] z, input logic m);
        int s;
        if (m) s = 4 + int'(ab);
        else if (z == 7'd27) s = 0;
        else if (z == 7'd54) s = 1;
        else if (z == 7'd81) s = 2;
        else s = 3;
        return int'(r) * 128 + s * 16;
    endfunction

    task automatic put(input int e, input logic [6:0] s, input logic [4:0] c);
        rom[e/4][(e%4)*12 +: 12] = {s, c};
    endtask

    function automatic logic [11:0] get(input int e);
        return rom[e/4][(e%4)*12 +: 12];
    endfunction

    task automatic clear_region(input int base);
        for (int l = 0; l < 16; l++) rom[base + l] = '0;
    endtask

    task automatic build(input int base, input int nb);
        int e;
        clear_region(base);
        e = base * 4;
        for (int r = 0; r < nb; r++) begin
            int d;
            d = 1 + int'($urandom % 12);
            put(e, 7'h7F, 5'(d)); e++;
            for (int j = 0; j < d; j++) begin
                put(e, 7'($urandom % 127), 5'($urandom % 32)); e++;
            end
        end
    endtask

    task automatic model(input int base, input int n);
        int e, rows;
        logic [11:0] ent;
        q_shift.delete(); q_col.delete(); q_deg.delete();
        q_first.delete(); q_last.delete();
        exp_err = 1'b0;
        e = base * 4;
        rows = 0;
        while (n != 0 && rows < n && !exp_err && e < 2040) begin
            int d;
            ent = get(e);
            if (ent[11:5] != 7'h7F || ent[4:0] == 5'd0) begin
                exp_err = 1'b1;
            end else begin
                d = int'(ent[4:0]);
                e++;
                for (int j = 0; j < d && !exp_err; j++) begin
                    ent = get(e);
                    if (ent[11:5] == 7'h7F) begin
                        exp_err = 1'b1;
                    end else begin
                        q_shift.push_back(ent[11:5]); q_col.push_back(ent[4:0]);
                        q_deg.push_back(5'(d));
                        q_first.push_back(j == 0); q_last.push_back(j == d - 1);
                        e++;
                    end
                end
                rows++;
            end
        end
    endtask

    task automatic pulse_start(input logic [1:0] r, input logic ab,
                               input logic [6:0] z, input logic m, input int n);
        @(negedge clk);
        cfg_rate = r; cfg_ab = ab; cfg_z = z; cfg_mode = m;
        num_rows = 6'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(input logic [1:0] r, input logic ab, input logic [6:0] z,
                            input logic m, input int n, input string tag);
        int base, idx, cyc;
        bit stalled;
        logic [6:0] s_sh; logic [4:0] s_co, s_dg; logic s_f, s_l;
        base = base_of(r, ab, z, m);
        model(base, n);
        pulse_start(r, ab, z, m, n);
        if (n != 0) begin
            chk(rom_rd && int'(rom_addr) == base, "R1", {tag, " start line"}, int'(rom_addr), base);
            chk(!done && !err, "R9", {tag, " flags cleared"}, int'({done, err}), 0);
        end
        idx = 0; cyc = 0; stalled = 1'b0;
        s_sh = '0; s_co = '0; s_dg = '0; s_f = 1'b0; s_l = 1'b0;
        while (!(done || err) && cyc < 3000) begin
            bit rdy;
            if (stalled) begin
                chk(out_valid && out_shift == s_sh && out_col == s_co && out_deg == s_dg &&
                    out_first == s_f && out_last == s_l, "R5", {tag, " hold"},
                    int'({out_valid, out_shift, out_col}), int'({1'b1, s_sh, s_co}));
            end else if (out_valid) begin
                if (idx < q_shift.size()) begin
                    chk(out_shift == q_shift[idx] && out_col == q_col[idx], "R2",
                        {tag, " pair"}, int'({out_shift, out_col}), int'({q_shift[idx], q_col[idx]}));
                    chk(out_deg == q_deg[idx] && out_first == q_first[idx] && out_last == q_last[idx],
                        "R3", {tag, " row tags"}, int'({out_deg, out_first, out_last}),
                        int'({q_deg[idx], q_first[idx], q_last[idx]}));
                end else begin
                    chk(1'b0, "R4", {tag, " extra pair"}, idx, q_shift.size());
                end
            end
            rdy = (int'($urandom % 4) >= stall_lvl);
            out_ready = rdy;
            stalled = out_valid && !rdy;
            if (out_valid && rdy) idx++;
            s_sh = out_shift; s_co = out_col; s_dg = out_deg; s_f = out_first; s_l = out_last;
            @(negedge clk);
            cyc++;
        end
        chk(idx == q_shift.size(), "R4", {tag, " pair count"}, idx, q_shift.size());
        chk(err == exp_err, exp_err ? "R6" : "R4", {tag, " err"}, int'(err), int'(exp_err));
        chk(done == !exp_err, "R4", {tag, " done"}, int'(done), int'(!exp_err));
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && done == !exp_err && err == exp_err, "R9", {tag, " sticky"},
            int'({out_valid, done, err}), int'({1'b0, !exp_err, exp_err}));
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int b;
        void'($urandom(32'd7));
        for (int l = 0; l < 512; l++) rom[l] = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !err && !rom_rd, "R10", "reset outputs",
            int'({out_valid, done, err, rom_rd}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R4: zero rows requested
        run_case(2'd1, 1'b0, 7'd54, 1'b0, 0, "zero rows");

        // R1 R2 R3: random tables over random regions, light stall
        for (int t = 0; t < 10; t++) begin
            logic [1:0] r; logic ab, m; logic [6:0] z; int nb, n, zc;
            r = 2'($urandom % 4); ab = 1'($urandom % 2); m = 1'($urandom % 2);
            zc = int'($urandom % 4);
            z = (zc == 0) ? 7'd27 : (zc == 1) ? 7'd54 : (zc == 2) ? 7'd81 : 7'($urandom % 128);
            nb = 1 + int'($urandom % 4);
            n = 1 + int'($urandom % nb);
            build(base_of(r, ab, z, m), nb);
            stall_lvl = (t < 5) ? 1 : 3;
            run_case(r, ab, z, m, n, "random");
        end
        stall_lvl = 1;

        // R6: zero-degree header after a good row
        b = base_of(2'd3, 1'b1, 7'd0, 1'b1);
        clear_region(b);
        put(b*4, 7'h7F, 5'd3); put(b*4+1, 7'd5, 5'd1); put(b*4+2, 7'd6, 5'd2);
        put(b*4+3, 7'd7, 5'd3); put(b*4+4, 7'h7F, 5'd0);
        run_case(2'd3, 1'b1, 7'd0, 1'b1, 2, "zero degree");
        chk(q_shift.size() == 3 && exp_err, "R6", "model pairs before error", q_shift.size(), 3);

        // R7: header inside a row
        b = base_of(2'd2, 1'b0, 7'd100, 1'b0);
        clear_region(b);
        put(b*4, 7'h7F, 5'd4); put(b*4+1, 7'd10, 5'd9); put(b*4+2, 7'd11, 5'd8);
        put(b*4+3, 7'h7F, 5'd5); put(b*4+4, 7'd1, 5'd1);
        run_case(2'd2, 1'b0, 7'd100, 1'b0, 1, "header in row R7");

        // R8: missing header
        b = base_of(2'd0, 1'b0, 7'd81, 1'b0);
        clear_region(b);
        run_case(2'd0, 1'b0, 7'd81, 1'b0, 1, "missing header R8");

        // R9: restart during a walk
        b = base_of(2'd1, 1'b1, 7'd0, 1'b1);
        build(b, 4);
        out_ready = 1'b1;
        pulse_start(2'd1, 1'b1, 7'd0, 1'b1, 4);
        repeat (6) @(negedge clk);
        b = base_of(2'd0, 1'b0, 7'd27, 1'b0);
        build(b, 3);
        run_case(2'd0, 1'b0, 7'd27, 1'b0, 3, "restart");

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule